// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block accepts one memory request at a time (bank, row, column, read or write, burst length code) and turns it into the command sequence an SDRAM expects. For a closed row it opens the row with an activate, waits the row-to-column delay, issues the column read or write and then counts the beats of the burst. The row stays open after the burst, so a later request to the same bank and row gets its column command at once. A request to any other row, or the expiry of an open-row time limit, closes the row with a precharge, and the next activate waits out the precharge recovery time.

The user side is a valid/ready request channel. A request is taken at a rising edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold every request field stable and must not drop `req_valid`. `req_ready` does not depend on `req_valid`. It is low whenever the sequencer is busy: waiting on a timer, counting a burst, or closing a row. The device side drives registered command pins, a bank select and a shared row/column address bus. `burst_beat` marks the cycles in which the current burst's beats are counted.

Top module: `sdram_row_seq`

## Requirements
- R1: A request is taken at a rising edge with `req_valid` and `req_ready` both high, and all request fields, including the burst length code, are captured at that edge. `req_ready` is high only when no row is open and `init_done` is high, or when a row is open, no burst is being counted and the open-row limit has not expired.
- R2: A request taken while no row is open puts an activate on the pins in the next cycle. The activate is {ras_n,cas_n,we_n}=011, with the request bank on `cmd_bank` and the row, zero-extended, on `cmd_addr`.
- R3: The column command comes exactly TRCD cycles after its activate. It is 101 for a read and 100 for a write, with the request bank on `cmd_bank` and the column, zero-extended, on `cmd_addr`.
- R4: `burst_beat` is high for exactly 1, 2, 4 or 8 consecutive cycles for burst codes 0, 1, 2 and 3, starting in the cycle of the column command. `req_ready` stays low in every one of those cycles.
- R5: While `init_done` is low and no row is open, `req_ready` stays low and no activate is issued, whatever `req_valid` does.
- R6: A request to the bank and row already open (a hit) puts its column command on the pins in the cycle after it is taken, with no activate in between.
- R7: A request to a different row or bank while a row is open (a miss) puts a precharge (010) for the open bank on the pins in the next cycle. The activate for the new row follows exactly TRP cycles after the precharge, and the column command follows TRCD cycles after that.
- R8: An open row that receives no request is precharged exactly OPEN_LIMIT cycles after its activate. `req_ready` stays low from the expiry until TRP cycles after the precharge, when it rises again.
- R9: In every cycle without a command the pins carry NOP (111). No encodings other than NOP, activate, read, write and precharge ever appear.
- R10: In reset the pins carry NOP, `burst_beat` is low and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_done | input | 1 | High once the device mode register has been set |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request at this edge |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request first column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 2 | Burst code: 0,1,2,3 give 1,2,4,8 beats |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_bank | output | BANK_W | Bank select |
| cmd_addr | output | ADDR_W | Row or column address |
| burst_beat | output | 1 | High in each counted beat of the burst |

## Verification
The bench checks hit timing at the edges: a request taken in the very cycle the row becomes idle, and a request arriving just before the open-row limit expires. A sequencer that reopened an already open row would show an extra activate. One that counted the limit from the wrong cycle would precharge a cycle early or late. Misses are checked for the precharge-to-activate and activate-to-column spacing, since a wait counter loaded with an off-by-one value moves the column command. Every burst code is checked for beat count, because a length decode that is off by one makes `burst_beat` one cycle short or long. A request held while `init_done` is low is checked for having no effect.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT_WAIT,
    ST_BURST,
    ST_OPEN,
    ST_PRE_WAIT
  } seq_state_t;

  // command pins ordered {ras_n, cas_n, we_n}
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_ACT = 3'b011;
  localparam logic [2:0] CMD_RD  = 3'b101;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_PRE = 3'b010;

  localparam int BEAT_W = 3;

  // beats in the burst, minus one, for a 2-bit length code
  function automatic logic [BEAT_W-1:0] beats_m1(input logic [1:0] code);
    case (code)
      2'd0:    beats_m1 = 3'd0;
      2'd1:    beats_m1 = 3'd1;
      2'd2:    beats_m1 = 3'd3;
      default: beats_m1 = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/seq_down_timer.sv
module seq_down_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/seq_open_limit.sv
module seq_open_limit #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  age <= '0;
    else if (restart)            age <= '0;
    else if (run && age != LAST) age <= age + 1'b1;
  end

  assign expired = (age == LAST);
endmodule

// File: rtl/sdram_row_seq.sv
module sdram_row_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter int TRCD       = 3,
  parameter int TRP        = 3,
  parameter int OPEN_LIMIT = 40,
  localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic [1:0]        req_burst,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              burst_beat
);
  localparam int MAXW   = (TRCD > TRP) ? TRCD : TRP;
  localparam int WAIT_W = $clog2(MAXW + 1);
  localparam logic [WAIT_W-1:0] RCD_LOAD = WAIT_W'(TRCD - 1);
  localparam logic [WAIT_W-1:0] RP_LOAD  = WAIT_W'(TRP - 1);

  seq_state_t state, nxt_state;
  logic [2:0]        cmd_q, nxt_cmd;
  logic [BANK_W-1:0] bank_q, nxt_bank;
  logic [ADDR_W-1:0] addr_q, nxt_addr;

  // captured request
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_write;
  logic [1:0]        cur_burst;
  logic              pend_q;

  // open-row bookkeeping
  logic              row_open;
  logic [BANK_W-1:0] open_bank;
  logic [ROW_W-1:0]  open_row;

  logic              wait_load, wait_zero;
  logic [WAIT_W-1:0] wait_val;
  logic              beat_load, beat_zero;
  logic [BEAT_W-1:0] beat_val;
  logic              lim_restart, lim_expired;
  logic              take, set_open, clr_open, set_pend, clr_pend;
  logic              accept, hit;

  seq_down_timer #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .load_val(wait_val), .zero(wait_zero)
  );

  seq_down_timer #(.W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(beat_load), .load_val(beat_val), .zero(beat_zero)
  );

  seq_open_limit #(.LIMIT(OPEN_LIMIT)) u_limit (
    .clk(clk), .rst_n(rst_n), .restart(lim_restart), .run(row_open), .expired(lim_expired)
  );

  always_comb begin
    case (state)
      ST_IDLE: req_ready = init_done;
      ST_OPEN: req_ready = !lim_expired;
      default: req_ready = 1'b0;
    endcase
  end

  assign accept = req_valid && req_ready;
  assign hit    = row_open && (req_bank == open_bank) && (req_row == open_row);

  always_comb begin
    nxt_state   = state;
    nxt_cmd     = CMD_NOP;
    nxt_bank    = bank_q;
    nxt_addr    = addr_q;
    wait_load   = 1'b0;
    wait_val    = '0;
    beat_load   = 1'b0;
    beat_val    = '0;
    lim_restart = 1'b0;
    take        = 1'b0;
    set_open    = 1'b0;
    clr_open    = 1'b0;
    set_pend    = 1'b0;
    clr_pend    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          take        = 1'b1;
          nxt_cmd     = CMD_ACT;
          nxt_bank    = req_bank;
          nxt_addr    = ADDR_W'(req_row);
          wait_load   = 1'b1;
          wait_val    = RCD_LOAD;
          lim_restart = 1'b1;
          set_open    = 1'b1;
          nxt_state   = ST_ACT_WAIT;
        end
      end
      ST_ACT_WAIT: begin
        if (wait_zero) begin
          nxt_cmd   = cur_write ? CMD_WR : CMD_RD;
          nxt_bank  = cur_bank;
          nxt_addr  = ADDR_W'(cur_col);
          beat_load = 1'b1;
          beat_val  = beats_m1(cur_burst);
          nxt_state = ST_BURST;
        end
      end
      ST_BURST: begin
        if (beat_zero) nxt_state = ST_OPEN;
      end
      ST_OPEN: begin
        if (accept) begin
          take = 1'b1;
          if (hit) begin
            nxt_cmd   = req_write ? CMD_WR : CMD_RD;
            nxt_bank  = req_bank;
            nxt_addr  = ADDR_W'(req_col);
            beat_load = 1'b1;
            beat_val  = beats_m1(req_burst);
            nxt_state = ST_BURST;
          end else begin
            nxt_cmd   = CMD_PRE;
            nxt_bank  = open_bank;
            nxt_addr  = '0;
            wait_load = 1'b1;
            wait_val  = RP_LOAD;
            clr_open  = 1'b1;
            set_pend  = 1'b1;
            nxt_state = ST_PRE_WAIT;
          end
        end else if (lim_expired) begin
          nxt_cmd   = CMD_PRE;
          nxt_bank  = open_bank;
          nxt_addr  = '0;
          wait_load = 1'b1;
          wait_val  = RP_LOAD;
          clr_open  = 1'b1;
          nxt_state = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (wait_zero) begin
          if (pend_q) begin
            nxt_cmd     = CMD_ACT;
            nxt_bank    = cur_bank;
            nxt_addr    = ADDR_W'(cur_row);
            wait_load   = 1'b1;
            wait_val    = RCD_LOAD;
            lim_restart = 1'b1;
            set_open    = 1'b1;
            clr_pend    = 1'b1;
            nxt_state   = ST_ACT_WAIT;
          end else begin
            nxt_state = ST_IDLE;
          end
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
    end else begin
      state  <= nxt_state;
      cmd_q  <= nxt_cmd;
      bank_q <= nxt_bank;
      addr_q <= nxt_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bank  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_write <= 1'b0;
      cur_burst <= '0;
    end else if (take) begin
      cur_bank  <= req_bank;
      cur_row   <= req_row;
      cur_col   <= req_col;
      cur_write <= req_write;
      cur_burst <= req_burst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      row_open  <= 1'b0;
      open_bank <= '0;
      open_row  <= '0;
    end else begin
      if (set_pend)      pend_q <= 1'b1;
      else if (clr_pend) pend_q <= 1'b0;
      if (set_open) begin
        row_open  <= 1'b1;
        open_bank <= nxt_bank;
        open_row  <= nxt_addr[ROW_W-1:0];
      end else if (clr_open) begin
        row_open <= 1'b0;
      end
    end
  end

  assign {cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;
  assign cmd_bank   = bank_q;
  assign cmd_addr   = addr_q;
  assign burst_beat = (state == ST_BURST);

endmodule

// File: rtl/sdram_row_seq_chk.sv
module sdram_row_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int TRCD = 3,
  parameter int TRP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic init_done,
  input logic req_ready,
  input logic cmd_ras_n,
  input logic cmd_cas_n,
  input logic cmd_we_n,
  input logic burst_beat
);
  logic [2:0] cmd;
  logic [7:0] since_act, since_pre;
  logic       open_seen;
  logic       is_act, is_pre, is_col;

  assign cmd    = {cmd_ras_n, cmd_cas_n, cmd_we_n};
  assign is_act = (cmd == CMD_ACT);
  assign is_pre = (cmd == CMD_PRE);
  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 8'hff;
      since_pre <= 8'hff;
      open_seen <= 1'b0;
    end else begin
      if (is_act)                 since_act <= 8'd1;
      else if (since_act != 8'hff) since_act <= since_act + 8'd1;
      if (is_pre)                 since_pre <= 8'd1;
      else if (since_pre != 8'hff) since_pre <= since_pre + 8'd1;
      if (is_act)      open_seen <= 1'b1;
      else if (is_pre) open_seen <= 1'b0;
    end
  end

  assert_col_after_trcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (open_seen && since_act >= 8'(TRCD)));

  assert_act_after_trp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (!open_seen && since_pre >= 8'(TRP)));

  assert_no_ready_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_beat |-> !req_ready);

  assert_act_needs_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> $past(init_done));

  assert_cmd_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) || is_act || is_pre || is_col);

  assert_pre_only_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> open_seen);

endmodule

bind sdram_row_seq sdram_row_seq_chk #(.TRCD(TRCD), .TRP(TRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_ready(req_ready),
  .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
  .burst_beat(burst_beat)
);

// File: tb/sdram_row_seq_test.sv
module sdram_row_seq_test;
  localparam int BANK_W = 2, ROW_W = 13, COL_W = 10;
  localparam int TRCD = 3, TRP = 3, OPEN_LIMIT = 40;
  localparam int ADDR_W = 13;

  logic clk = 1'b0, rst_n = 1'b0, init_done = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [1:0]        req_burst = '0;
  logic cmd_ras_n, cmd_cas_n, cmd_we_n, burst_beat;
  logic [BANK_W-1:0] cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;

  sdram_row_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .TRCD(TRCD), .TRP(TRP), .OPEN_LIMIT(OPEN_LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .req_burst(req_burst), .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .burst_beat(burst_beat));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int bank; int row; int col; int wr; int blc; int acc; } item_t;
  item_t q[$];

  int act_count = 0, last_act = -1000, last_pre = -1000, act_bank = 0, act_row = 0;
  int col_c = -1000, col_bl = 0;

  function automatic int beats_of(input int code);
    return 1 << code;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // command monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] c;
      item_t it;
      bit exp_beat;
      c = {cmd_ras_n, cmd_cas_n, cmd_we_n};
      case (c)
        3'b111: ;
        3'b011: begin
          act_count++; last_act = cyc; act_bank = int'(cmd_bank); act_row = int'(cmd_addr);
        end
        3'b010: begin
          chk(int'(cmd_bank) == act_bank, "R7 precharge bank", int'(cmd_bank), act_bank);
          last_pre = cyc;
        end
        3'b101, 3'b100: begin
          if (q.size() == 0) chk(1'b0, "R3 column with no request", 0, 1);
          else begin
            it = q.pop_front();
            chk(int'(cmd_bank) == it.bank, "R3 column bank", int'(cmd_bank), it.bank);
            chk(int'(cmd_addr) == it.col, "R3 column addr", int'(cmd_addr), it.col);
            chk(int'(c == 3'b100) == it.wr, "R3 column direction", int'(c == 3'b100), it.wr);
            chk(act_bank == it.bank && act_row == it.row, "R2 open row matches", act_row, it.row);
            if (last_act > it.acc) begin
              chk(cyc - last_act == TRCD, "R3 activate to column", cyc - last_act, TRCD);
              if (last_pre > it.acc) begin
                chk(last_pre == it.acc + 1, "R7 precharge after miss", last_pre, it.acc + 1);
                chk(last_act - last_pre == TRP, "R7 precharge to activate", last_act - last_pre, TRP);
              end else begin
                chk(last_act == it.acc + 1, "R2 activate after accept", last_act, it.acc + 1);
              end
            end else begin
              chk(cyc == it.acc + 1, "R6 hit column timing", cyc, it.acc + 1);
            end
            col_c = cyc; col_bl = beats_of(it.blc);
          end
        end
        default: chk(1'b0, "R9 illegal command", int'(c), 7);
      endcase
      exp_beat = (cyc >= col_c) && (cyc < col_c + col_bl);
      if (exp_beat || burst_beat)
        chk(burst_beat == exp_beat, "R4 burst beat", int'(burst_beat), int'(exp_beat));
    end
  end

  task automatic send(input int b, input int r, input int c, input int w, input int blc);
    item_t it;
    req_bank = BANK_W'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
    req_write = w[0]; req_burst = 2'(blc); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    it.bank = b; it.row = r; it.col = c; it.wr = w; it.blc = blc; it.acc = cyc;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pc;
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b111, "R10 reset command", int'({cmd_ras_n, cmd_cas_n, cmd_we_n}), 7);
    chk(!burst_beat, "R10 reset beat", int'(burst_beat), 0);
    chk(!req_ready, "R10 reset ready", int'(req_ready), 0);
    @(negedge clk); rst_n = 1'b1;

    // R5 request held without init_done has no effect
    req_valid = 1'b1; req_bank = 2'd1; req_row = 13'd9;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!req_ready, "R5 ready low before init", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    chk(act_count == 0, "R5 no activate before init", act_count, 0);
    init_done = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready in idle after init", int'(req_ready), 1);

    // R2 R3 R4 fresh read, then R6 hits, every burst code
    send(1, 5, 8, 0, 2);
    send(1, 5, 16, 1, 3);
    send(1, 5, 3, 0, 0);
    send(1, 5, 20, 1, 1);
    drain();

    // R7 miss: other row, then other bank
    send(1, 6, 40, 0, 2);
    send(2, 6, 41, 1, 0);
    drain();

    // R8 forced close with no traffic
    begin
      int a0;
      send(3, 100, 7, 0, 1);
      drain();
      a0 = last_act;
      pc = -1;
      while (pc < 0) begin
        @(negedge clk);
        if ({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b010) pc = cyc;
      end
      chk(pc - a0 == OPEN_LIMIT, "R8 open limit close", pc - a0, OPEN_LIMIT);
      for (int i = 1; i < TRP; i++) begin
        @(negedge clk);
        chk(!req_ready, "R8 ready low during close", int'(req_ready), 0);
      end
      @(negedge clk);
      chk(req_ready, "R8 ready back after close", int'(req_ready), 1);
    end

    // R1 random stream, mixed hits and misses, gaps around the limit
    for (int n = 0; n < 150; n++) begin
      int gap;
      send(int'($urandom_range(1, 0)), int'($urandom_range(2, 0)),
           int'($urandom_range(1023, 0)), int'($urandom_range(1, 0)),
           int'($urandom_range(3, 0)));
      gap = int'($urandom_range(45, 0));
      repeat (gap) @(negedge clk);
    end
    drain();
    chk(q.size() == 0, "R1 all requests served", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule